// File: doc/BRIEF.md
# Byte-Coded Fetch and Decode Sequencer

This block is the control core of a small 8-bit processor. It reads one opcode byte at a time from a 256-byte unified memory and decodes it from bit fields. It then reads the operand bytes that follow and leaves the program counter on the next opcode. The opcode byte states how many operands it carries and which class it belongs to, so decoding needs no table. The sequencer holds eight 8-bit registers, one of which is the stack pointer. It also holds a three-bit flags register.

The sequencer carries out the data-movement, stack, output and control-transfer instructions itself. Arithmetic and compare instructions go out to an external combinational ALU. The sequencer supplies the operation code and both register values, then writes back the result and flags the ALU returns. Interrupt entry and return belong to a separate unit, so the sequencer treats those codes as errors. Printing is a one-cycle strobe that carries a value and a number/character tag.

Top module: `byte_cpu_seq`

## Requirements
- R1: After reset the program counter is 0, so the first fetch address is 0. R7 (stack pointer) holds 0xF4 and the flags are 0. halt_o, err_o, out_valid_o and mem_we_o are low.
- R2: The opcode byte is decoded by fields. Bits 7:6 give the operand count (0, 1 or 2). Bit 5 marks the ALU class. Bit 4 marks the PC-setting class. Bits 3:0 give the code within the class. Operands come from the bytes that follow the opcode, and the PC moves past them by 1 plus the operand count.
- R3: Code 7 (PRN) and code 8 (PRA) in the plain class raise out_valid_o for exactly one cycle, with the first-operand register on out_data_o. out_is_char_o is 0 for code 7 and 1 for code 8. Code 2 (LDI) loads the first-operand register with the second operand byte.
- R4: Code 3 (LD) loads register A from the memory address held in register B. Code 4 (ST) writes register B to the memory address held in register A.
- R5: Code 5 (PUSH) decrements R7 and then writes register A to memory at the new R7. Code 6 (POP) reads memory at R7 into register A and then increments R7.
- R6: In the PC-setting class, code 0 (CALL) pushes the address of the byte after its operand and loads the PC from register A. Code 1 (RET) pops the PC.
- R7: Code 4 (JMP) in the PC-setting class always loads the PC from register A. The conditional jumps use flag bit 0 (equal), bit 1 (greater) and bit 2 (less). Code 5 jumps on bit 0. Code 6 jumps on bit 0 clear. Code 7 jumps on bit 1. Code 8 jumps on bit 2. Code 9 jumps on bit 0 or bit 2. Code 10 jumps on bit 0 or bit 1. A jump that is not taken goes on at the byte after its operand.
- R8: An ALU-class opcode pulses alu_valid_o for one cycle. alu_op_o carries bits 3:0, alu_a_o carries register A, and alu_b_o carries register B, or 0 when there is one operand. alu_res_i is written to register A when alu_res_we_i is high. alu_flags_i is written to the flags when alu_flags_we_i is high.
- R9: Code 1 (HLT) in the plain class stops the sequencer with halt_o high until reset. After that there are no further memory writes and no output strobes.
- R10: Any unrecognised opcode sets err_o and halts. This covers an operand count of 3, plain-class codes 0 and 9 to 15, and PC-setting codes 2, 3 and 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| alu_valid_o | output | 1 | ALU operation strobe |
| alu_op_o | output | 4 | ALU operation code |
| alu_a_o | output | 8 | ALU first operand value |
| alu_b_o | output | 8 | ALU second operand value |
| alu_res_i | input | 8 | ALU result |
| alu_res_we_i | input | 1 | Write the result to register A |
| alu_flags_i | input | 3 | ALU flags {less, greater, equal} |
| alu_flags_we_i | input | 1 | Write the flags |
| out_valid_o | output | 1 | Output strobe |
| out_is_char_o | output | 1 | 1 for a character, 0 for a number |
| out_data_o | output | 8 | Output value |
| halt_o | output | 1 | Sequencer halted |
| err_o | output | 1 | Unrecognised instruction seen |

## Verification
The hardest situation to reach is a conditional jump whose flags were set by a compare that really ran through the ALU path. The flags cannot be forced from the ports. The stimulus therefore runs a short program that loads two values, compares them and then jumps. It sweeps every jump code over equal, greater and less operand pairs. The bench works out whether each jump should be taken from the value pair and the code, then checks which of two print paths ran. Stack order, the CALL return address, and the POP into the stack pointer are reached the same way, through the memory image the bench models.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;
  typedef enum logic [2:0] {
    S_FETCH, S_OPC, S_OPA, S_OPD, S_EXEC, S_MEMW, S_HALT
  } seq_state_e;

  // plain class codes
  localparam logic [3:0] C_HLT  = 4'd1;
  localparam logic [3:0] C_LDI  = 4'd2;
  localparam logic [3:0] C_LD   = 4'd3;
  localparam logic [3:0] C_ST   = 4'd4;
  localparam logic [3:0] C_PUSH = 4'd5;
  localparam logic [3:0] C_POP  = 4'd6;
  localparam logic [3:0] C_PRN  = 4'd7;
  localparam logic [3:0] C_PRA  = 4'd8;

  // pc-setting class codes
  localparam logic [3:0] P_CALL = 4'd0;
  localparam logic [3:0] P_RET  = 4'd1;
  localparam logic [3:0] P_JMP  = 4'd4;
  localparam logic [3:0] P_JEQ  = 4'd5;
  localparam logic [3:0] P_JNE  = 4'd6;
  localparam logic [3:0] P_JGT  = 4'd7;
  localparam logic [3:0] P_JLT  = 4'd8;
  localparam logic [3:0] P_JLE  = 4'd9;
  localparam logic [3:0] P_JGE  = 4'd10;

  localparam int FL_EQ = 0;
  localparam int FL_GT = 1;
  localparam int FL_LT = 2;
  localparam int FLW   = 3;
endpackage

// File: rtl/cpu_jump_cond.sv
module cpu_jump_cond
  import cpu_seq_pkg::*;
(
  input  logic [3:0]     code_i,
  input  logic [FLW-1:0] fl_i,
  output logic           is_jump_o,
  output logic           take_o
);
  always_comb begin
    is_jump_o = 1'b1;
    take_o    = 1'b0;
    case (code_i)
      P_JMP:   take_o = 1'b1;
      P_JEQ:   take_o = fl_i[FL_EQ];
      P_JNE:   take_o = !fl_i[FL_EQ];
      P_JGT:   take_o = fl_i[FL_GT];
      P_JLT:   take_o = fl_i[FL_LT];
      P_JLE:   take_o = fl_i[FL_EQ] | fl_i[FL_LT];
      P_JGE:   take_o = fl_i[FL_EQ] | fl_i[FL_GT];
      default: is_jump_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int              NREG   = 8,
  parameter int              DW     = 8,
  parameter int              SP_IDX = 7,
  parameter logic [DW-1:0]   SP_RST = 8'hF4,
  localparam int             RW     = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ra_a_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [RW-1:0] ra_b_i,
  output logic [DW-1:0] rd_b_o,
  input  logic          we_a_i,
  input  logic [RW-1:0] wa_i,
  input  logic [DW-1:0] wd_a_i,
  input  logic          we_s_i,
  input  logic [DW-1:0] wd_s_i,
  output logic [DW-1:0] sp_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          r_q <= (g == SP_IDX) ? SP_RST : '0;
      else if (we_a_i && wa_i == RW'(g))    r_q <= wd_a_i;   // port A wins over SP port
      else if (g == SP_IDX && we_s_i)       r_q <= wd_s_i;
    end
    assign regs[g] = r_q;
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
  assign sp_o   = regs[SP_IDX];

  AST_SP_PORT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_i && wa_i == RW'(SP_IDX) && we_s_i) |=> sp_o == $past(wd_a_i)); // R5
endmodule

// File: rtl/byte_cpu_seq.sv
module byte_cpu_seq
  import cpu_seq_pkg::*;
#(
  parameter int            DW     = 8,
  parameter int            AW     = 8,
  parameter int            NREG   = 8,
  parameter logic [DW-1:0] SP_RST = 8'hF4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           alu_valid_o,
  output logic [3:0]     alu_op_o,
  output logic [DW-1:0]  alu_a_o,
  output logic [DW-1:0]  alu_b_o,
  input  logic [DW-1:0]  alu_res_i,
  input  logic           alu_res_we_i,
  input  logic [2:0]     alu_flags_i,
  input  logic           alu_flags_we_i,
  output logic           out_valid_o,
  output logic           out_is_char_o,
  output logic [DW-1:0]  out_data_o,
  output logic           halt_o,
  output logic           err_o
);
  localparam int RW     = $clog2(NREG);
  localparam int SP_IDX = NREG - 1;

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  pc_q, pc_d;
  logic [7:0]     ir_q;
  logic [RW-1:0]  op0_q;
  logic [DW-1:0]  op1_q;
  logic           idx_q;
  logic [FLW-1:0] fl_q;
  logic           err_q, err_d;

  logic [1:0]     cnt;
  logic           is_alu, is_pc;
  logic [3:0]     code;
  assign cnt    = ir_q[7:6];
  assign is_alu = ir_q[5];
  assign is_pc  = ir_q[4];
  assign code   = ir_q[3:0];

  logic [DW-1:0]  rd_a, rd_b, sp;
  logic           rf_we, sp_we;
  logic [DW-1:0]  rf_wd, sp_wd;
  logic           jc_is_jump, jc_take;

  cpu_regfile #(.NREG(NREG), .DW(DW), .SP_IDX(SP_IDX), .SP_RST(SP_RST)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(op0_q), .rd_a_o(rd_a),
    .ra_b_i(op1_q[RW-1:0]), .rd_b_o(rd_b),
    .we_a_i(rf_we), .wa_i(op0_q), .wd_a_i(rf_wd),
    .we_s_i(sp_we), .wd_s_i(sp_wd), .sp_o(sp)
  );

  cpu_jump_cond u_jc (.code_i(code), .fl_i(fl_q), .is_jump_o(jc_is_jump), .take_o(jc_take));

  always_comb begin
    state_d       = state_q;
    pc_d          = pc_q;
    err_d         = err_q;
    mem_addr_o    = pc_q;
    mem_we_o      = 1'b0;
    mem_wdata_o   = '0;
    rf_we         = 1'b0;
    rf_wd         = '0;
    sp_we         = 1'b0;
    sp_wd         = sp;
    alu_valid_o   = 1'b0;
    out_valid_o   = 1'b0;
    out_is_char_o = 1'b0;
    out_data_o    = '0;
    case (state_q)
      S_FETCH: state_d = S_OPC;
      S_OPC: begin
        pc_d = pc_q + 1'b1;
        if (mem_rdata_i[7:6] == 2'd3) begin
          err_d   = 1'b1;
          state_d = S_HALT;
        end else if (mem_rdata_i[7:6] == 2'd0) state_d = S_EXEC;
        else                                   state_d = S_OPA;
      end
      S_OPA: state_d = S_OPD;
      S_OPD: begin
        pc_d    = pc_q + 1'b1;
        state_d = (idx_q || cnt == 2'd1) ? S_EXEC : S_OPA;
      end
      S_EXEC: begin
        state_d = S_FETCH;
        if (is_alu) begin
          alu_valid_o = 1'b1;
          rf_we       = alu_res_we_i;
          rf_wd       = alu_res_i;
        end else if (is_pc) begin
          if (code == P_CALL) begin
            sp_we       = 1'b1;
            sp_wd       = sp - 1'b1;
            mem_addr_o  = AW'(sp - 1'b1);
            mem_we_o    = 1'b1;
            mem_wdata_o = DW'(pc_q);
            pc_d        = AW'(rd_a);
          end else if (code == P_RET) begin
            mem_addr_o = AW'(sp);
            state_d    = S_MEMW;
          end else if (jc_is_jump) begin
            if (jc_take) pc_d = AW'(rd_a);
          end else begin
            err_d   = 1'b1;
            state_d = S_HALT;
          end
        end else begin
          case (code)
            C_HLT: state_d = S_HALT;
            C_LDI: begin
              rf_we = 1'b1;
              rf_wd = op1_q;
            end
            C_LD: begin
              mem_addr_o = AW'(rd_b);
              state_d    = S_MEMW;
            end
            C_ST: begin
              mem_addr_o  = AW'(rd_a);
              mem_we_o    = 1'b1;
              mem_wdata_o = rd_b;
            end
            C_PUSH: begin
              sp_we       = 1'b1;
              sp_wd       = sp - 1'b1;
              mem_addr_o  = AW'(sp - 1'b1);
              mem_we_o    = 1'b1;
              mem_wdata_o = rd_a;
            end
            C_POP: begin
              mem_addr_o = AW'(sp);
              state_d    = S_MEMW;
            end
            C_PRN, C_PRA: begin
              out_valid_o   = 1'b1;
              out_is_char_o = (code == C_PRA);
              out_data_o    = rd_a;
            end
            default: begin
              err_d   = 1'b1;
              state_d = S_HALT;
            end
          endcase
        end
      end
      S_MEMW: begin
        state_d = S_FETCH;
        if (is_pc) begin  // RET
          pc_d  = AW'(mem_rdata_i);
          sp_we = 1'b1;
          sp_wd = sp + 1'b1;
        end else begin    // LD or POP; POP into R7 keeps the loaded byte
          rf_we = 1'b1;
          rf_wd = mem_rdata_i;
          if (code == C_POP) begin
            sp_we = 1'b1;
            sp_wd = sp + 1'b1;
          end
        end
      end
      default: state_d = S_HALT;
    endcase
  end

  assign alu_op_o = code;
  assign alu_a_o  = rd_a;
  assign alu_b_o  = (cnt == 2'd2) ? rd_b : '0;
  assign halt_o   = (state_q == S_HALT);
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      op0_q   <= '0;
      op1_q   <= '0;
      idx_q   <= 1'b0;
      fl_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      err_q   <= err_d;
      if (state_q == S_OPC) begin
        ir_q  <= mem_rdata_i[7:0];
        idx_q <= 1'b0;
      end
      if (state_q == S_OPD) begin
        idx_q <= 1'b1;
        if (!idx_q) op0_q <= mem_rdata_i[RW-1:0];
        else        op1_q <= mem_rdata_i;
      end
      if (state_q == S_EXEC && is_alu && alu_flags_we_i) fl_q <= alu_flags_i;
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R9
  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_we_o && !out_valid_o); // R9
  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> halt_o); // R10
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R3
  AST_ALU_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |=> !alu_valid_o); // R8
  AST_PUSH_SP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC && !is_alu && !is_pc && code == C_PUSH) |=> sp == $past(sp) - 1'b1); // R5
  AST_OPC_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OPC) |=> pc_q == $past(pc_q) + 1'b1); // R2
endmodule

// File: tb/sim_byte_cpu_seq.sv
`timescale 1ns/1ps
module sim_byte_cpu_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata;
  logic       mem_we_o;
  logic       alu_valid, alu_rwe, alu_fwe;
  logic [3:0] alu_op;
  logic [7:0] alu_a, alu_b, alu_res;
  logic [2:0] alu_fl;
  logic       out_valid_o, out_is_char_o, halt_o, err_o;
  logic [7:0] out_data_o;

  always #4 clk_i = ~clk_i;

  byte_cpu_seq u0 (
    .clk_i, .rst_ni,
    .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i(mem_rdata),
    .alu_valid_o(alu_valid), .alu_op_o(alu_op), .alu_a_o(alu_a), .alu_b_o(alu_b),
    .alu_res_i(alu_res), .alu_res_we_i(alu_rwe), .alu_flags_i(alu_fl), .alu_flags_we_i(alu_fwe),
    .out_valid_o, .out_is_char_o, .out_data_o, .halt_o, .err_o
  );

  // ALU model: 0 add, 5 increment (a+b+1, b must be 0), 7 compare
  always_comb begin
    alu_res = '0; alu_rwe = 1'b0; alu_fl = '0; alu_fwe = 1'b0;
    if (alu_valid) begin
      case (alu_op)
        4'd0: begin alu_res = alu_a + alu_b; alu_rwe = 1'b1; end
        4'd5: begin alu_res = alu_a + alu_b + 8'd1; alu_rwe = 1'b1; end
        4'd7: begin
          alu_fwe = 1'b1;
          alu_fl  = (alu_a == alu_b) ? 3'b001 : (alu_a > alu_b) ? 3'b010 : 3'b100;
        end
        default: ;
      endcase
    end
  end

  // memory model with backdoor port
  logic [7:0] mem [256];
  logic       bd_we = 1'b0;
  logic [7:0] bd_addr = '0, bd_data = '0;
  always @(posedge clk_i) begin
    if (bd_we)         mem[bd_addr] <= bd_data;
    else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata <= mem[mem_addr_o];
  end

  int n_chk = 0, n_fail = 0, cyc_all = 0;
  logic [7:0] prog [64];
  int plen;
  logic [7:0] od [16];
  logic       oc [16];
  int n_out;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc_all++;
    if (cyc_all > 190000) begin
      n_fail++;
      $display("FAIL watchdog: cycles %0d expected below 190000", cyc_all);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic emit(input int n, input logic [7:0] b0, input logic [7:0] b1 = 0, input logic [7:0] b2 = 0);
    prog[plen] = b0;
    if (n > 1) prog[plen+1] = b1;
    if (n > 2) prog[plen+2] = b2;
    plen += n;
  endtask

  task automatic run_prog();
    int cyc;
    int extra;
    rst_ni = 1'b0;
    @(negedge clk_i);
    for (int i = 0; i < plen; i++) begin
      bd_addr = i[7:0]; bd_data = prog[i]; bd_we = 1'b1;
      @(negedge clk_i);
    end
    bd_we = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk("R1 first fetch address", mem_addr_o, 8'h00);
    n_out = 0; cyc = 0;
    while (!halt_o && cyc < 3000) begin
      @(negedge clk_i);
      if (out_valid_o && n_out < 16) begin
        od[n_out] = out_data_o; oc[n_out] = out_is_char_o; n_out++;
      end
      cyc++;
    end
    chk("R9 halt reached", {31'd0, halt_o}, 32'd1);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (out_valid_o || mem_we_o || !halt_o) extra++;
    end
    chk("R9 quiet after halt", extra, 0);
  endtask

  function automatic logic exp_take(input int code, input int a, input int b);
    case (code)
      4:  return 1'b1;
      5:  return a == b;
      6:  return a != b;
      7:  return a > b;
      8:  return a < b;
      9:  return a <= b;
      10: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    int pa [3];
    int pb [3];
    logic [7:0] bad [6];
    pa[0] = 3; pb[0] = 3; pa[1] = 9; pb[1] = 2; pa[2] = 1; pb[2] = 8;

    // R1 reset state
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 halt low", {31'd0, halt_o}, 32'd0);
    chk("R1 err low", {31'd0, err_o}, 32'd0);
    chk("R1 out strobe low", {31'd0, out_valid_o}, 32'd0);
    chk("R1 write low", {31'd0, mem_we_o}, 32'd0);

    // R5 R1 stack: PRN R7; LDI R0,5A; PUSH R0; PRN R7; POP R1; PRN R1; PRN R7; HLT
    plen = 0;
    emit(2, 8'h47, 8'h07); emit(3, 8'h82, 8'h00, 8'h5A); emit(2, 8'h45, 8'h00);
    emit(2, 8'h47, 8'h07); emit(2, 8'h46, 8'h01); emit(2, 8'h47, 8'h01);
    emit(2, 8'h47, 8'h07); emit(1, 8'h01);
    run_prog();
    chk("R5 output count", n_out, 4);
    chk("R1 sp reset value", od[0], 8'hF4);
    chk("R5 sp after push", od[1], 8'hF3);
    chk("R5 popped value", od[2], 8'h5A);
    chk("R5 sp after pop", od[3], 8'hF4);
    chk("R5 pushed byte in memory", mem[8'hF3], 8'h5A);
    chk("R3 number tag", {31'd0, oc[2]}, 32'd0);

    // R5 pop into R7: LDI R0,0x33; PUSH R0; POP R7; PRN R7; HLT -> loaded byte wins
    plen = 0;
    emit(3, 8'h82, 8'h00, 8'h33); emit(2, 8'h45, 8'h00); emit(2, 8'h46, 8'h07);
    emit(2, 8'h47, 8'h07); emit(1, 8'h01);
    run_prog();
    chk("R5 pop into sp", od[0], 8'h33);

    // R4 R3: LDI R0,80; LDI R1,41; ST R0,R1; LD R2,R0; PRA R2; HLT
    plen = 0;
    emit(3, 8'h82, 8'h00, 8'h80); emit(3, 8'h82, 8'h01, 8'h41);
    emit(3, 8'h84, 8'h00, 8'h01); emit(3, 8'h83, 8'h02, 8'h00);
    emit(2, 8'h48, 8'h02); emit(1, 8'h01);
    run_prog();
    chk("R4 stored byte", mem[8'h80], 8'h41);
    chk("R4 loaded value", od[0], 8'h41);
    chk("R3 character tag", {31'd0, oc[0]}, 32'd1);
    chk("R3 one strobe", n_out, 1);

    // R6: LDI R0,11; CALL R0; LDI R1,22; PRN R1; HLT; sub@11: LDI R1,77; PRN R1; RET
    plen = 0;
    emit(3, 8'h82, 8'h00, 8'd11); emit(2, 8'h50, 8'h00); emit(3, 8'h82, 8'h01, 8'h22);
    emit(2, 8'h47, 8'h01); emit(1, 8'h01);
    emit(3, 8'h82, 8'h01, 8'h77); emit(2, 8'h47, 8'h01); emit(1, 8'h11);
    run_prog();
    chk("R6 output count", n_out, 2);
    chk("R6 subroutine ran first", od[0], 8'h77);
    chk("R6 returned after call", od[1], 8'h22);
    chk("R6 return address pushed", mem[8'hF3], 8'd5);

    // R8 R2: LDI R0,5; LDI R1,7; ADD R0,R1; PRN R0; INC R0; PRN R0; HLT
    plen = 0;
    emit(3, 8'h82, 8'h00, 8'd5); emit(3, 8'h82, 8'h01, 8'd7); emit(3, 8'hA0, 8'h00, 8'h01);
    emit(2, 8'h47, 8'h00); emit(2, 8'h65, 8'h00); emit(2, 8'h47, 8'h00); emit(1, 8'h01);
    run_prog();
    chk("R8 add result", od[0], 8'd12);
    chk("R8 one-operand b is zero", od[1], 8'd13);
    chk("R2 operand walk output count", n_out, 2);

    // R7 conditional jump sweep
    for (int code = 4; code <= 10; code++) begin
      for (int p = 0; p < 3; p++) begin
        plen = 0;
        emit(3, 8'h82, 8'h00, pa[p][7:0]); emit(3, 8'h82, 8'h01, pb[p][7:0]);
        emit(3, 8'hA7, 8'h00, 8'h01); emit(3, 8'h82, 8'h02, 8'd20);
        emit(2, 8'h50 | code[7:0], 8'h02);
        emit(3, 8'h82, 8'h03, 8'h00); emit(2, 8'h47, 8'h03); emit(1, 8'h01);
        emit(3, 8'h82, 8'h03, 8'h01); emit(2, 8'h47, 8'h03); emit(1, 8'h01);
        run_prog();
        chk($sformatf("R7 jump code %0d a=%0d b=%0d", code, pa[p], pb[p]),
            {24'd0, od[0]}, {31'd0, exp_take(code, pa[p], pb[p])});
      end
    end

    // R10 unrecognised opcodes: PRN R7; <bad>,00; PRN R7; HLT
    bad[0] = 8'h0F; bad[1] = 8'h00; bad[2] = 8'h52; bad[3] = 8'h53;
    bad[4] = 8'h5F; bad[5] = 8'hC1;
    for (int k = 0; k < 6; k++) begin
      plen = 0;
      emit(2, 8'h47, 8'h07); emit(2, bad[k], 8'h00); emit(2, 8'h47, 8'h07); emit(1, 8'h01);
      run_prog();
      chk($sformatf("R10 err for 0x%0h", bad[k]), {31'd0, err_o}, 32'd1);
      chk($sformatf("R10 stopped after 0x%0h", bad[k]), n_out, 1);
    end

    // R9 HLT is not an error
    plen = 0;
    emit(1, 8'h01);
    run_prog();
    chk("R9 clean halt no err", {31'd0, err_o}, 32'd0);

    summary();
  end
endmodule